// File: doc/BRIEF.md
# Run-Gated Timestamp Tick and Counter

This block produces the timestamp tick for a data acquisition system and keeps a running timestamp count. The tick comes from one of two sources: an internal divider that emits one enable pulse every four system clock cycles, or an external clock line. The external line is brought into the system clock domain and reduced to one pulse per rising edge. All ticks are single-cycle clock-enable pulses in the system clock domain. The selected tick drives a local counter and a tick output, so that other timestamp counters further down the chain can count the same pulses.

A run flag gates the tick stream. Two explicit commands set and clear the flag. While the flag is low, no tick leaves the block, the counter holds its value, and a clear command returns the counter to zero. The start-up sequence clears every counter while the flag is low and sets the flag as its last step. All counters then begin counting together. The internal divider phase restarts when the flag rises, so the first tick arrives a fixed number of cycles after the set command.

Top module: `run_gated_timestamp`

## Requirements
- R1: After reset, `tick_out` is 0, `ts_value` is 0 and the run flag is low, so no tick is emitted until `go_set` is applied.
- R2: With `src_ext` = 0 and the run flag high, `tick_out` is high for exactly one cycle in every DIV (default 4) cycles, and `ts_value` increases by one in the same cycle that `tick_out` is high.
- R3: When `go_set` is sampled at clock edge E0 while the flag is low, the first internal tick appears on `tick_out` (and in `ts_value`) right after edge E0+DIV. A run that is stopped by `go_clr` sampled at edge E0+p has counted exactly floor(p/DIV) ticks.
- R4: While the run flag is low, `tick_out` stays 0 and `ts_value` holds its value, whatever the external clock line does.
- R5: `go_clr` lowers the run flag from the next cycle onward. If `go_set` and `go_clr` are asserted in the same cycle, the clear wins.
- R6: `cnt_clear` sampled while the run flag is low sets `ts_value` to 0 on the next cycle.
- R7: `cnt_clear` sampled while the run flag is high has no effect on `ts_value`.
- R8: With `src_ext` = 1 and the run flag high, each rising edge of `ext_clk_in` (each level held for at least one cycle) gives exactly one single-cycle pulse on `tick_out`. A high level first sampled at edge E0 shows on `tick_out` right after edge E0+2.
- R9: `ts_value` is CNT_W bits wide (default 48) and wraps from all-ones to 0 without any other effect.
- R10: The source that is not selected has no effect. The internal divider adds no ticks when `src_ext` = 1, and `ext_clk_in` adds none when `src_ext` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_in | input | 1 | External timestamp clock, asynchronous to `clk` |
| src_ext | input | 1 | Tick source: 0 = internal divider, 1 = external clock |
| go_set | input | 1 | Command pulse that raises the run flag |
| go_clr | input | 1 | Command pulse that lowers the run flag (wins over `go_set`) |
| cnt_clear | input | 1 | Command that zeroes the counter; acted on only while stopped |
| tick_out | output | 1 | Gated single-cycle tick for other timestamp counters |
| ts_value | output | CNT_W | Timestamp count |

## Verification
The hardest case to reach from the ports is the counter wrap, because the default width needs 2^48 ticks. The bench therefore builds the block with a 6-bit counter and runs the internal divider for 300 cycles, which crosses the wrap. A second case is the exact tick count of a run that is stopped partway through a divider period. The bench sweeps the run length from 1 to 13 cycles and compares the final count against floor(p/4). A third case is external edges that come close together. The bench sweeps every high/low level length from one to three cycles and counts the pulses one by one.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tick_src_e;

  function automatic int phase_width(input int div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/ts_sync_edge.sv
module ts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], async_in};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/ts_phase_div.sv
module ts_phase_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int PW = ts_pkg::phase_width(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run)      phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                  phase <= phase + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_div
      assign tick = run && (phase == LAST);
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_pass
      assign tick = run;
    end
  endgenerate

endmodule

// File: rtl/ts_run_ctrl.sv
module ts_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic go_set,
  input  logic go_clr,
  output logic run
);

  always_ff @(posedge clk) begin
    if (rst)         run <= 1'b0;
    else if (go_clr) run <= 1'b0;
    else if (go_set) run <= 1'b1;
  end

  // R5
  go_clear_chk: assert property (@(posedge clk) disable iff (rst)
    go_clr |=> !run);

  // R3
  go_set_chk: assert property (@(posedge clk) disable iff (rst)
    (go_set && !go_clr) |=> run);

endmodule

// File: rtl/ts_count.sv
module ts_count #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst)              value <= '0;
    else if (!run && clr) value <= '0;
    else if (inc)         value <= value + 1'b1;
  end

  // R6
  clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && clr) |=> (value == '0));

  // R7
  clear_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (run && clr && !inc) |=> $stable(value));

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(value));

endmodule

// File: rtl/run_gated_timestamp.sv
module run_gated_timestamp #(
  parameter int CNT_W       = 48,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_clk_in,
  input  logic             src_ext,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic             cnt_clear,
  output logic             tick_out,
  output logic [CNT_W-1:0] ts_value
);

  import ts_pkg::*;

  logic      run;
  logic      div_tick;
  logic      ext_rise;
  logic      gated;
  tick_src_e src_sel;

  ts_run_ctrl i_run (
    .clk    (clk),
    .rst    (rst),
    .go_set (go_set),
    .go_clr (go_clr),
    .run    (run)
  );

  ts_phase_div #(.DIV(DIV)) i_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (div_tick)
  );

  ts_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_clk_in),
    .rise     (ext_rise)
  );

  assign src_sel = tick_src_e'(src_ext);
  assign gated   = run && ((src_sel == SRC_EXTERNAL) ? ext_rise : div_tick);

  always_ff @(posedge clk) begin
    if (rst) tick_out <= 1'b0;
    else     tick_out <= gated;
  end

  ts_count #(.W(CNT_W)) i_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .clr   (cnt_clear),
    .inc   (gated),
    .value (ts_value)
  );

  // R4
  no_tick_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick_out);

  // R2
  tick_count_chk: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> (ts_value == CNT_W'($past(ts_value) + 1'b1)));

endmodule

// File: tb/test_run_gated_timestamp.sv
module test_run_gated_timestamp;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int MODV       = 1 << CNT_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ext_clk_in = 1'b0;
  logic             src_ext = 1'b0;
  logic             go_set = 1'b0;
  logic             go_clr = 1'b0;
  logic             cnt_clear = 1'b0;
  logic             tick_out;
  logic [CNT_W-1:0] ts_value;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  run_gated_timestamp #(.CNT_W(CNT_W), .DIV(4), .SYNC_STAGES(2)) i_run_gated_timestamp (
    .clk        (clk),
    .rst        (rst),
    .ext_clk_in (ext_clk_in),
    .src_ext    (src_ext),
    .go_set     (go_set),
    .go_clr     (go_clr),
    .cnt_clear  (cnt_clear),
    .tick_out   (tick_out),
    .ts_value   (ts_value)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_val(input string req, input int exp);
    check(int'(ts_value) == (exp % MODV), req, ts_value, exp % MODV);
  endtask

  task automatic chk_tick(input string req, input bit exp);
    check(tick_out == exp, req, tick_out, exp);
  endtask

  task automatic pulse_set();
    go_set = 1'b1; cyc(); go_set = 1'b0;
  endtask

  task automatic pulse_clr();
    go_clr = 1'b1; cyc(); go_clr = 1'b0;
  endtask

  task automatic pulse_zero();
    cnt_clear = 1'b1; cyc(); cnt_clear = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int rises;
    int pulses;
    bit prev_tick;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1: reset state, nothing happens without go_set
    chk_tick("R1", 1'b0);
    chk_val("R1", 0);
    repeat (8) cyc();
    chk_val("R1 idle", 0);

    // R2 R3 R7 R9 R10: internal source, clear while running ignored, ext toggling ignored
    src_ext = 1'b0;
    pulse_set();
    for (int k = 1; k <= 300; k++) begin
      cnt_clear  = (k % 7 == 0);
      ext_clk_in = k[1];
      cyc();
      chk_tick((k == 4) ? "R3" : "R2", (k % 4) == 0);
      chk_val((k % 7 == 1) ? "R7" : "R2", k / 4);
      if (k == 256) chk_val("R9", 0);
    end
    cnt_clear = 1'b0;

    // R5 R4: stop and hold
    pulse_clr();
    chk_val("R5", 75);
    for (int k = 0; k < 12; k++) begin
      ext_clk_in = k[0];
      cyc();
      chk_tick("R4", 1'b0);
      chk_val("R4", 75);
    end
    ext_clk_in = 1'b0;

    // R6
    pulse_zero();
    chk_val("R6", 0);

    // R3: runs of length p count floor(p/4)
    for (int p = 1; p <= 13; p++) begin
      pulse_set();
      repeat (p - 1) cyc();
      pulse_clr();
      repeat (3) cyc();
      chk_val("R3 partial run", p / 4);
      pulse_zero();
      chk_val("R6", 0);
    end

    // R5: set and clear together, clear wins
    go_set = 1'b1; go_clr = 1'b1; cyc(); go_set = 1'b0; go_clr = 1'b0;
    repeat (10) cyc();
    chk_val("R5 both", 0);
    chk_tick("R5 both", 1'b0);

    // R8: external source latency
    src_ext = 1'b1;
    ext_clk_in = 1'b0;
    repeat (4) cyc();
    pulse_set();
    repeat (6) cyc();
    chk_val("R10 divider ignored", 0);
    ext_clk_in = 1'b1;
    cyc(); chk_tick("R8", 1'b0);
    cyc(); chk_tick("R8", 1'b0);
    cyc(); chk_tick("R8", 1'b1); chk_val("R8", 1);
    cyc(); chk_tick("R8", 1'b0);
    ext_clk_in = 1'b0;
    repeat (3) cyc();

    // R8 R10: level-length sweep
    rises = 0; pulses = 0; prev_tick = 1'b0;
    for (int h = 1; h <= 3; h++) begin
      for (int l = 1; l <= 3; l++) begin
        for (int r = 0; r < 3; r++) begin
          ext_clk_in = 1'b1;
          rises++;
          for (int c = 0; c < h + l; c++) begin
            if (c == h) ext_clk_in = 1'b0;
            cyc();
            if (tick_out) pulses++;
            if (tick_out && prev_tick) check(1'b0, "R8 single pulse", 2, 1);
            prev_tick = tick_out;
          end
        end
      end
    end
    for (int c = 0; c < 5; c++) begin
      cyc();
      if (tick_out) pulses++;
    end
    check(pulses == rises, "R8 pulse count", pulses, rises);
    chk_val("R8 count", 1 + rises);

    // R4: external edges while stopped
    pulse_clr();
    repeat (3) cyc();
    for (int k = 0; k < 10; k++) begin
      ext_clk_in = ~ext_clk_in;
      cyc(); cyc();
      chk_tick("R4 ext", 1'b0);
    end
    chk_val("R4 ext", 1 + rises);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule